// File: doc/BRIEF.md
# GPIO Edge-Event Interrupt Unit

This block monitors a wide set of general-purpose input pins, organised as banks of 32 pins each. Every pin has two enable bits, one for rising transitions and one for falling transitions. When an enabled transition is seen, the pin's sticky event bit is set. Software reads the event bits and clears them by writing ones. Each input passes through a two-stage synchroniser before any edge is detected, so pins may be driven from asynchronous sources.

Three interrupt lines leave the block. Pin 0 and pin 1 each have their own line. A third line is the OR of the event bits of every other pin in every bank. A 2-bit alternate-function code per pin comes from the pad multiplexer. While that code is nonzero, the pin is not used as a plain input and edge detection on it is blocked.

Registers are reached through a strobe bus with a word address. The upper address bits select the bank and the two low bits select the register within that bank. Read data appears one cycle after the read strobe.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every rising enable, falling enable and event bit reads 0, and all three interrupt outputs are low.
- R2: Address bits [ADDR_W-1:2] select the bank and bits [1:0] select the register: 0 is rising enable, 1 is falling enable, 2 is event status, and 3 reads as zero. Enable registers read back the value last written to them. regRdData holds the selected word from the clock edge that samples regRdEn.
- R3: With its rising enable set, a 0-to-1 change on a pin sets that pin's event bit. The bit becomes visible after the third rising clock edge that follows the change, and it stays set after the pin returns to its old level.
- R4: With its falling enable set, a 1-to-0 change sets the event bit. With both enables set, a change in either direction sets it.
- R5: A pin change in a direction whose enable is 0 leaves the event bit unchanged.
- R6: A write to a status register clears each event bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. Writes to the status register never set a bit.
- R7: If an enabled edge and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R8: irqPin0 and irqPin1 equal the event bits of pin 0 and pin 1 of bank 0.
- R9: irqMux is high exactly when some event bit other than pins 0 and 1 of bank 0 is set, in any bank.
- R10: While a pin's alternate-function code (pinAltFunc bits [2p+1:2p] for pin p) is nonzero, changes on that pin set no event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gpioIn | input | 128 | Raw pin levels, asynchronous |
| pinAltFunc | input | 256 | 2-bit alternate-function code per pin |
| regWrEn | input | 1 | Single-cycle write strobe |
| regRdEn | input | 1 | Single-cycle read strobe |
| regAddr | input | 4 | Word address: bank and register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| irqPin0 | output | 1 | Interrupt for pin 0 |
| irqPin1 | output | 1 | Interrupt for pin 1 |
| irqMux | output | 1 | Combined interrupt for all other pins |

## Verification
The bench drives an edge on a pin at the same moment as a clearing write to that bit. A design that lets the clear win would drop the event and read the bit as 0. Random patterns exercise pins in banks 1 to 3 and pins 2 and 3 of bank 0. A combined line that skipped the upper banks, or that included pins 0 and 1, would then disagree with the model. Writes of zeros, and edges in a disabled direction, catch a design that disturbs event bits it should leave alone. Random alternate-function codes on toggling pins catch detection that ignores the code or that decodes the wrong bit pair.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    KIND_RISE = 2'd0,
    KIND_FALL = 2'd1,
    KIND_STAT = 2'd2,
    KIND_NONE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic     riseWr;
    logic     fallWr;
    logic     statClr;
    logic     rdEn;
    regKind_e kind;
  } regStrobe_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_IDX_W = 2,
  parameter int ADDR_W     = BANK_IDX_W + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [ADDR_W-1:0]     regAddr,
  output regStrobe_t            strb,
  output logic [BANK_IDX_W-1:0] bankSel
);

  logic     bankOk;
  regKind_e kindSel;

  assign bankSel = regAddr[ADDR_W-1:2];
  assign bankOk  = ({1'b0, bankSel} < (BANK_IDX_W + 1)'(NUM_BANKS));
  assign kindSel = regKind_e'(regAddr[1:0]);

  always_comb begin
    strb         = '0;
    strb.kind    = bankOk ? kindSel : KIND_NONE;
    strb.rdEn    = regRdEn;
    if (regWrEn && bankOk) begin
      unique case (kindSel)
        KIND_RISE: strb.riseWr  = 1'b1;
        KIND_FALL: strb.fallWr  = 1'b1;
        KIND_STAT: strb.statClr = 1'b1;
        default:   ;
      endcase
    end
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.riseWr, strb.fallWr, strb.statClr}));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = 32,
  parameter int BANK_IDX_W = 2,
  parameter int NPINS      = NUM_BANKS * BANK_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NPINS-1:0]      pinSync,
  input  logic [2*NPINS-1:0]    altFunc,
  input  regStrobe_t            strb,
  input  logic [BANK_IDX_W-1:0] bankSel,
  input  logic [BANK_W-1:0]     wrData,
  output logic [BANK_W-1:0]     rdData,
  output logic                  irqPin0,
  output logic                  irqPin1,
  output logic                  irqMux
);

  localparam logic [NPINS-1:0] DEDICATED = NPINS'(3);

  logic [NPINS-1:0] pinPrev;
  logic [NPINS-1:0] riseEn;
  logic [NPINS-1:0] fallEn;
  logic [NPINS-1:0] statQ;
  logic [NPINS-1:0] altBusy;
  logic [NPINS-1:0] edgeHit;
  logic [NPINS-1:0] clrVec;
  logic [NUM_BANKS-1:0] bankHit;

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinSync;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_alt
    assign altBusy[p] = |altFunc[2*p +: 2];
  end

  assign edgeHit = ((pinSync & ~pinPrev & riseEn) |
                    (~pinSync & pinPrev & fallEn)) & ~altBusy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankHit[b] = (bankSel == BANK_IDX_W'(b));
    assign clrVec[b*BANK_W +: BANK_W] =
      (strb.statClr && bankHit[b]) ? wrData : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseEn[b*BANK_W +: BANK_W] <= '0;
        fallEn[b*BANK_W +: BANK_W] <= '0;
      end else begin
        if (strb.riseWr && bankHit[b]) riseEn[b*BANK_W +: BANK_W] <= wrData;
        if (strb.fallWr && bankHit[b]) fallEn[b*BANK_W +: BANK_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrVec) | edgeHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      unique case (strb.kind)
        KIND_RISE: rdData <= riseEn[int'(bankSel)*BANK_W +: BANK_W];
        KIND_FALL: rdData <= fallEn[int'(bankSel)*BANK_W +: BANK_W];
        KIND_STAT: rdData <= statQ[int'(bankSel)*BANK_W +: BANK_W];
        default:   rdData <= '0;
      endcase
    end
  end

  assign irqPin0 = statQ[0];
  assign irqPin1 = statQ[1];
  assign irqMux  = |(statQ & ~DEDICATED);

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(edgeHit)) == '0));

  // R7
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeHit) & ~statQ) == '0));

  // R6
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statClr |=> ((~statQ & $past(statQ)) == '0));

  // R10
  alt_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & $past(altBusy)) == '0));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = 32,
  parameter int NPINS      = NUM_BANKS * BANK_W,
  parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  parameter int ADDR_W     = BANK_IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NPINS-1:0]     gpioIn,
  input  logic [2*NPINS-1:0]   pinAltFunc,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BANK_W-1:0]    regWrData,
  output logic [BANK_W-1:0]    regRdData,
  output logic                 irqPin0,
  output logic                 irqPin1,
  output logic                 irqMux
);

  logic [NPINS-1:0]      pinSync;
  regStrobe_t            strb;
  logic [BANK_IDX_W-1:0] bankSel;

  gpio_sync #(.WIDTH(NPINS)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (gpioIn),
    .dout (pinSync)
  );

  gpio_irq_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_IDX_W (BANK_IDX_W),
    .ADDR_W     (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb),
    .bankSel (bankSel)
  );

  gpio_irq_datapath #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .BANK_IDX_W (BANK_IDX_W),
    .NPINS      (NPINS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinSync (pinSync),
    .altFunc (pinAltFunc),
    .strb    (strb),
    .bankSel (bankSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqPin0 (irqPin0),
    .irqPin1 (irqPin1),
    .irqMux  (irqMux)
  );

endmodule

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NP = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] gpioIn = '0;
  logic [2*NP-1:0] pinAltFunc = '0;
  logic          regWrEn = 1'b0;
  logic          regRdEn = 1'b0;
  logic [3:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqPin0, irqPin1, irqMux;

  int nChecks = 0;
  int nFails  = 0;

  logic [NP-1:0] mRise = '0, mFall = '0, mStat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq dut (
    .clk(clk), .rstN(rstN), .gpioIn(gpioIn), .pinAltFunc(pinAltFunc),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .irqPin0(irqPin0), .irqPin1(irqPin1), .irqMux(irqMux)
  );

  function automatic logic [NP-1:0] busyOf(input logic [2*NP-1:0] a);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = |a[2*p +: 2];
    return r;
  endfunction

  function automatic logic [NP-1:0] edgesOf(input logic [NP-1:0] oldV,
      input logic [NP-1:0] newV, input logic [2*NP-1:0] a);
    return ((~oldV & newV & mRise) | (oldV & ~newV & mFall)) & ~busyOf(a);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] bank, input logic [1:0] kind, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = {bank, kind}; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (kind == 2'd0) mRise[bank*32 +: 32] = d;
    if (kind == 2'd1) mFall[bank*32 +: 32] = d;
    if (kind == 2'd2) mStat[bank*32 +: 32] = mStat[bank*32 +: 32] & ~d;
  endtask

  task automatic rdReg(input logic [1:0] bank, input logic [1:0] kind, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = {bank, kind};
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic setPins(input logic [NP-1:0] v);
    @(negedge clk);
    mStat = mStat | edgesOf(gpioIn, v, pinAltFunc);
    gpioIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input string req);
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rdReg(2'(b), 2'd0, d); check({req, " R2 rise"}, d, mRise[b*32 +: 32]);
      rdReg(2'(b), 2'd1, d); check({req, " R2 fall"}, d, mFall[b*32 +: 32]);
      rdReg(2'(b), 2'd2, d); check({req, " stat"}, d, mStat[b*32 +: 32]);
      rdReg(2'(b), 2'd3, d); check("R2 kind3", d, 32'h0);
    end
    check("R8 irqPin0", 32'(irqPin0), 32'(mStat[0]));
    check("R8 irqPin1", 32'(irqPin1), 32'(mStat[1]));
    check("R9 irqMux", 32'(irqMux), 32'(|(mStat & ~NP'(3))));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [NP-1:0] v;
    void'($urandom(32'h1badcafe));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 irqPin0", 32'(irqPin0), 32'h0);
    check("R1 irqPin1", 32'(irqPin1), 32'h0);
    check("R1 irqMux", 32'(irqMux), 32'h0);
    checkAll("R1");

    // R5 edges with no enable
    setPins(NP'(32'hffff_ffff) << 32);
    setPins('0);
    checkAll("R5");

    // R3 rising on pin 0 only, sticky after return
    wrReg(0, 0, 32'h0000_0001);
    setPins(NP'(1));
    check("R3 irqPin0", 32'(irqPin0), 32'h1);
    check("R9 irqMux ded", 32'(irqMux), 32'h0);
    setPins('0);
    checkAll("R3");

    // R4 falling on pin 1, both edges on pin 70
    wrReg(0, 1, 32'h0000_0002);
    wrReg(2, 0, 32'h0000_0040);
    wrReg(2, 1, 32'h0000_0040);
    setPins(NP'(2) | (NP'(1) << 70));
    check("R4 irqPin1 no rise", 32'(irqPin1), 32'h0);
    wrReg(2, 2, 32'h0000_0040);
    setPins('0);
    check("R4 irqPin1", 32'(irqPin1), 32'h1);
    check("R9 irqMux bank2", 32'(irqMux), 32'h1);
    checkAll("R4");

    // R6 write zero keeps, write one clears
    wrReg(0, 2, 32'h0);
    wrReg(2, 2, 32'h0);
    checkAll("R6 zero");
    wrReg(0, 2, 32'h3);
    wrReg(2, 2, 32'h0000_0040);
    checkAll("R6 ones");

    // R7 edge and clear collide on pin 5
    wrReg(0, 0, 32'h0000_0020);
    setPins(NP'(1) << 5);
    setPins('0);
    @(negedge clk) gpioIn = NP'(1) << 5;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin regWrEn = 1'b1; regAddr = 4'h2; regWrData = 32'h20; end
    @(negedge clk) regWrEn = 1'b0;
    rdReg(0, 2, d);
    check("R7 collide", d, 32'h0000_0020);
    wrReg(0, 2, 32'h20);
    rdReg(0, 2, d);
    check("R6 clear after", d, 32'h0);
    setPins('0);

    // R10 alt function blocks pin 40
    wrReg(1, 0, 32'hffff_ffff);
    @(negedge clk) pinAltFunc = 256'(2'b10) << 80;
    setPins(NP'(1) << 40);
    check("R10 irqMux", 32'(irqMux), 32'h0);
    @(negedge clk) pinAltFunc = '0;
    setPins('0);
    setPins(NP'(1) << 40);
    check("R10 restore", 32'(irqMux), 32'h1);
    checkAll("R10");

    // random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        for (int w = 0; w < NB; w++) v[w*32 +: 32] = $urandom() & $urandom();
        setPins(gpioIn ^ v);
      end else if (op < 7) begin
        wrReg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 2)), $urandom());
      end else if (op < 8) begin
        @(negedge clk);
        for (int p = 0; p < NP; p++)
          pinAltFunc[2*p +: 2] = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      end else begin
        checkAll("R3 R4 R5 R6 R10 rand");
      end
    end
    checkAll("R9 final");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule